// File: doc/BRIEF.md
# Dual-Button Delayed Reset Controller

This synchronous controller produces a hard system reset only after two active-low push-buttons have been held down together for a long, selectable qualification time. A brief press, or a press of only one button, never resets the system. The same buttons can therefore also drive an interrupt line, which gives the processor a chance to respond before a hard reset is forced.

A two-bit selector chooses the qualification time. It encodes a three-state strap: grounded, left open, or tied high. Once the time has elapsed, two reset outputs assert on the same clock edge. Output 1 is active-high and its pulse length is set by an input. Output 2 is active-low and its pulse length is fixed by a parameter. A digital undervoltage flag also holds both outputs active. After the flag clears, each output stays active for its own pulse length. All timing counts a one-millisecond tick input, not the clock.

Top module: `dual_button_reset_ctrl`

## Requirements
- R1: The qualification timer advances only while both synchronized button inputs are low. If either input is high, the timer clears and no reset is produced.
- R2: The selector sets the qualification time in ticks. Code 2'b00 gives SETUP_SHORT (default 2000), 2'b01 gives SETUP_MID (default 6000), and 2'b10 or 2'b11 gives SETUP_LONG (default 10000).
- R3: With ticks on every clock, both outputs become active together after exactly setup+3 clock edges counted from the first edge that sees both buttons low. This count includes the two synchronizer stages.
- R4: rst1_o is active-high and rst2_n_o is active-low. In reset and at idle, rst1_o=0 and rst2_n_o=1.
- R5: Each rst2_n_o pulse lasts PULSE2_TICKS ticks (default 210).
- R6: Each rst1_o pulse lasts the number of ticks on pulse1_len, sampled when the pulse starts. A typical setting is 360.
- R7: While uv_flag is high, both outputs are active. After it falls, each output stays active for its own pulse length and then releases.
- R8: Holding both buttons down after a reset never starts another one. At least one button must be released first.
- R9: If uv_flag rises during a pulse, both pulse timers restart in full when the flag falls.
- R10: A press of both buttons that is shorter than the qualification time never causes a reset.
- R11: All timers change only on clock edges where tick_ms is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_ms | input | 1 | One-cycle timebase pulse, one per millisecond |
| btn0_n | input | 1 | First push-button, active low, asynchronous |
| btn1_n | input | 1 | Second push-button, active low, asynchronous |
| dly_sel | input | 2 | Qualification time selector (00 ground, 01 open, 1x high) |
| pulse1_len | input | P1_W | Pulse length of output 1, in ticks |
| uv_flag | input | 1 | Undervoltage flag, synchronous, active high |
| rst1_o | output | 1 | Reset output 1, active high |
| rst2_n_o | output | 1 | Reset output 2, active low |

## Verification
Two events can land in the same cycle: the end of the button qualification, which reloads both pulse timers, and a change of the undervoltage flag, which also reloads them. The bench raises the flag in the middle of a button-started pulse and then clears it. It checks that both pulse lengths are counted again from the falling edge of the flag and not from the original start. A behavioural model that counts in plain integers is compared with both outputs on every falling clock edge. Fixed-offset checks also pin the exact edge on which each output switches.

// File: rtl/drbr_pkg.sv
package drbr_pkg;
   typedef enum logic [1:0] {
      SEL_GND  = 2'b00,
      SEL_OPEN = 2'b01,
      SEL_HIGH = 2'b10,
      SEL_RSVD = 2'b11
   } dly_sel_e;

   function automatic int unsigned pick_setup(input logic [1:0] sel,
                                              input int unsigned s_short,
                                              input int unsigned s_mid,
                                              input int unsigned s_long);
      case (dly_sel_e'(sel))
         SEL_GND:  return s_short;
         SEL_OPEN: return s_mid;
         default:  return s_long;
      endcase
   endfunction
endpackage

// File: rtl/drbr_sync.sv
module drbr_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("drbr_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= {W{RST_VAL}};
         end else if (s == 0) begin
            stage_q[s] <= d_i;
         end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/drbr_setup_timer.sv
module drbr_setup_timer
   import drbr_pkg::*;
#(
   parameter int unsigned SETUP_SHORT = 2000,
   parameter int unsigned SETUP_MID   = 6000,
   parameter int unsigned SETUP_LONG  = 10000,
   localparam int CW = $clog2(SETUP_LONG + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       both_low_i,
   input  logic [1:0] sel_i,
   output logic       fire_o
);
   if (!(SETUP_SHORT > 0 && SETUP_SHORT < SETUP_MID && SETUP_MID < SETUP_LONG)) begin : g_bad_order
      $error("drbr_setup_timer: setup times must be nonzero and increasing");
   end

   logic [CW-1:0] cnt_q;
   logic          armed_q;
   logic [CW-1:0] last_cnt;

   assign last_cnt = CW'(pick_setup(sel_i, SETUP_SHORT, SETUP_MID, SETUP_LONG) - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b1;
         fire_o  <= 1'b0;
      end else begin
         fire_o <= 1'b0;
         if (!both_low_i) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
         end else if (armed_q && tick_i) begin
            if (cnt_q >= last_cnt) begin
               cnt_q   <= '0;
               armed_q <= 1'b0;
               fire_o  <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   // R1: a qualification end needs both buttons low on the deciding edge
   assert_fire_needs_both_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> $past(both_low_i));
   // R8: no second qualification without a release in between
   assert_no_rearm_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_o && both_low_i) |=> !fire_o);
   // R11: the count holds when no tick arrives
   assert_cnt_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (both_low_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/drbr_pulse_timer.sv
module drbr_pulse_timer #(
   parameter int W           = 16,
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         load_i,
   input  logic         hold_i,
   input  logic [W-1:0] len_i,
   output logic         rst_o
);
   logic [W-1:0] rem_q;
   logic         active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else if (load_i) begin
         rem_q <= len_i;
      end else if (tick_i && rem_q != '0) begin
         rem_q <= rem_q - 1'b1;
      end
   end

   assign active = hold_i || (rem_q != '0);

   if (ACTIVE_HIGH) begin : g_pol_high
      assign rst_o = active;
   end else begin : g_pol_low
      assign rst_o = ~active;
   end

   // R7: a load captures the requested length
   assert_load_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> rem_q == $past(len_i));
   // R11: without a tick the remaining time is frozen
   assert_hold_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !tick_i) |=> $stable(rem_q));
   // R11: each tick takes one unit off a running pulse
   assert_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && tick_i && rem_q != '0) |=> rem_q == $past(rem_q) - 1'b1);
endmodule

// File: rtl/dual_button_reset_ctrl.sv
module dual_button_reset_ctrl
   import drbr_pkg::*;
#(
   parameter int unsigned SETUP_SHORT  = 2000,
   parameter int unsigned SETUP_MID    = 6000,
   parameter int unsigned SETUP_LONG   = 10000,
   parameter int unsigned PULSE2_TICKS = 210,
   parameter int          P1_W         = 16,
   parameter int          SYNC_STAGES  = 2,
   localparam int         P2_W         = $clog2(PULSE2_TICKS + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_ms,
   input  logic            btn0_n,
   input  logic            btn1_n,
   input  logic [1:0]      dly_sel,
   input  logic [P1_W-1:0] pulse1_len,
   input  logic            uv_flag,
   output logic            rst1_o,
   output logic            rst2_n_o
);
   if (PULSE2_TICKS == 0) begin : g_bad_p2
      $error("dual_button_reset_ctrl: PULSE2_TICKS must be nonzero");
   end
   if (P1_W < 1) begin : g_bad_p1w
      $error("dual_button_reset_ctrl: P1_W must be positive");
   end

   logic [1:0] btn_s;
   logic       both_low;
   logic       fire;
   logic       uv_q;
   logic       load;

   drbr_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({btn1_n, btn0_n}),
      .q_o   (btn_s)
   );

   assign both_low = (btn_s == 2'b00);

   drbr_setup_timer #(
      .SETUP_SHORT (SETUP_SHORT),
      .SETUP_MID   (SETUP_MID),
      .SETUP_LONG  (SETUP_LONG)
   ) u_setup (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_ms),
      .both_low_i (both_low),
      .sel_i      (dly_sel),
      .fire_o     (fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) uv_q <= 1'b0;
      else        uv_q <= uv_flag;
   end

   assign load = uv_q || fire;

   drbr_pulse_timer #(.W(P1_W), .ACTIVE_HIGH(1'b1)) u_pulse1 (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_ms),
      .load_i (load),
      .hold_i (uv_q),
      .len_i  (pulse1_len),
      .rst_o  (rst1_o)
   );

   drbr_pulse_timer #(.W(P2_W), .ACTIVE_HIGH(1'b0)) u_pulse2 (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_ms),
      .load_i (load),
      .hold_i (uv_q),
      .len_i  (P2_W'(PULSE2_TICKS)),
      .rst_o  (rst2_n_o)
   );

   // R3: qualification end drives the active-low output on the next edge
   assert_fire_asserts_out2_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !rst2_n_o);
   // R3: both outputs switch on together when a nonzero length is set
   assert_same_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && pulse1_len != '0) |=> (rst1_o && !rst2_n_o));
   // R7: a registered undervoltage keeps both outputs active
   assert_uv_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(uv_flag) |-> (rst1_o && !rst2_n_o));
endmodule

// File: tb/dual_button_reset_ctrl_tb_top.sv
module dual_button_reset_ctrl_tb_top;
   localparam int P1W = 16;
   localparam int S_SHORT = 2000, S_MID = 6000, S_LONG = 10000, P2 = 210;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_ms = 1'b1;
   logic btn0_n = 1'b1, btn1_n = 1'b1;
   logic [1:0] dly_sel = 2'b00;
   logic [P1W-1:0] pulse1_len = 16'd360;
   logic uv_flag = 1'b0;
   logic rst1_o, rst2_n_o;

   int n_cmp = 0, n_bad = 0;
   int tick_div = 1;
   int cyc = 0;
   string cur_req = "R4";

   always #5 clk = ~clk;

   dual_button_reset_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .btn0_n(btn0_n), .btn1_n(btn1_n),
      .dly_sel(dly_sel), .pulse1_len(pulse1_len), .uv_flag(uv_flag),
      .rst1_o(rst1_o), .rst2_n_o(rst2_n_o)
   );

   // timebase
   always @(negedge clk) begin
      cyc <= cyc + 1;
      tick_ms <= ((cyc + 1) % tick_div) == 0;
   end

   // behavioural reference
   logic [1:0] m_s1, m_s2;
   int m_cnt, m_r1, m_r2;
   bit m_armed, m_fire, m_uv;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = 2'b11; m_s2 = 2'b11; m_cnt = 0; m_armed = 1;
         m_fire = 0; m_uv = 0; m_r1 = 0; m_r2 = 0;
      end else begin
         automatic int lim = (dly_sel == 2'b00) ? S_SHORT : (dly_sel == 2'b01) ? S_MID : S_LONG;
         automatic bit fire_n = 0;
         automatic bit ld = m_uv || m_fire;
         if (m_s2 != 2'b00) begin
            m_cnt = 0; m_armed = 1;
         end else if (m_armed && tick_ms) begin
            if (m_cnt >= lim - 1) begin m_cnt = 0; m_armed = 0; fire_n = 1; end
            else m_cnt++;
         end
         if (ld) m_r1 = int'(pulse1_len); else if (tick_ms && m_r1 > 0) m_r1--;
         if (ld) m_r2 = P2;               else if (tick_ms && m_r2 > 0) m_r2--;
         m_uv = uv_flag;
         m_fire = fire_n;
         m_s2 = m_s1;
         m_s1 = {btn1_n, btn0_n};
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         automatic bit e1 = m_uv || (m_r1 != 0);
         automatic bit e2 = !(m_uv || (m_r2 != 0));
         n_cmp++;
         if (rst1_o !== e1 || rst2_n_o !== e2) begin
            n_bad++;
            $display("FAIL %s model: rst1=%b rst2_n=%b expected %b %b at cycle %0d",
                     cur_req, rst1_o, rst2_n_o, e1, e2, cyc);
         end
      end
   end

   task automatic chk(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cyc);
      end
   endtask

   task automatic wait_n(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic both(input logic v);
      btn0_n = v; btn1_n = v;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      wait_n(3);
      chk("R4 reset rst1", rst1_o, 1'b0);
      chk("R4 reset rst2_n", rst2_n_o, 1'b1);
      @(negedge clk); rst_n = 1'b1;
      wait_n(5);

      // R10: short press of both
      cur_req = "R10";
      both(1'b0); wait_n(S_SHORT - 10); both(1'b1);
      wait_n(50);
      chk("R10 short press rst1", rst1_o, 1'b0);
      chk("R10 short press rst2_n", rst2_n_o, 1'b1);

      // R1: one button only, longer than any setup
      cur_req = "R1";
      btn0_n = 1'b0; wait_n(S_SHORT + 500);
      chk("R1 single button", rst1_o, 1'b0);
      btn0_n = 1'b1; wait_n(10);

      // R3/R5/R6: grounded selector, exact edges
      cur_req = "R3";
      dly_sel = 2'b00; pulse1_len = 16'd360;
      both(1'b0);
      wait_n(S_SHORT + 2);
      chk("R3 not yet rst1", rst1_o, 1'b0);
      chk("R3 not yet rst2_n", rst2_n_o, 1'b1);
      wait_n(1);
      chk("R3 rst1 on", rst1_o, 1'b1);
      chk("R3 rst2_n on", rst2_n_o, 1'b0);
      cur_req = "R5";
      wait_n(P2 - 1);
      chk("R5 rst2_n last", rst2_n_o, 1'b0);
      wait_n(1);
      chk("R5 rst2_n end", rst2_n_o, 1'b1);
      cur_req = "R6";
      wait_n(360 - P2 - 1);
      chk("R6 rst1 last", rst1_o, 1'b1);
      wait_n(1);
      chk("R6 rst1 end", rst1_o, 1'b0);

      // R8: keep holding, no retrigger
      cur_req = "R8";
      wait_n(S_SHORT + 1000);
      chk("R8 held no retrigger", rst1_o, 1'b0);
      both(1'b1); wait_n(10);

      // R2: open selector
      cur_req = "R2";
      dly_sel = 2'b01;
      both(1'b0);
      wait_n(S_MID + 2);
      chk("R2 mid not yet", rst1_o, 1'b0);
      wait_n(1);
      chk("R2 mid fires", rst1_o, 1'b1);
      both(1'b1); wait_n(400);

      // R2: code 11 behaves as high
      dly_sel = 2'b11;
      both(1'b0);
      wait_n(S_LONG + 2);
      chk("R2 long not yet", rst2_n_o, 1'b1);
      wait_n(1);
      chk("R2 long fires", rst2_n_o, 1'b0);
      both(1'b1); wait_n(400);
      dly_sel = 2'b00;

      // R7: undervoltage hold then own lengths
      cur_req = "R7";
      uv_flag = 1'b1; wait_n(60);
      chk("R7 uv rst1", rst1_o, 1'b1);
      chk("R7 uv rst2_n", rst2_n_o, 1'b0);
      uv_flag = 1'b0;
      wait_n(P2);
      chk("R7 rst2_n after uv last", rst2_n_o, 1'b0);
      wait_n(1);
      chk("R7 rst2_n after uv end", rst2_n_o, 1'b1);
      wait_n(360 - P2 - 1);
      chk("R7 rst1 after uv last", rst1_o, 1'b1);
      wait_n(1);
      chk("R7 rst1 after uv end", rst1_o, 1'b0);
      wait_n(20);

      // R9: undervoltage in the middle of a pulse restarts both
      cur_req = "R9";
      both(1'b0); wait_n(S_SHORT + 3); both(1'b1);
      wait_n(100);
      uv_flag = 1'b1; wait_n(20); uv_flag = 1'b0;
      wait_n(P2);
      chk("R9 rst2_n restarted", rst2_n_o, 1'b0);
      wait_n(1);
      chk("R9 rst2_n restart end", rst2_n_o, 1'b1);
      wait_n(200);

      // R6: a short programmed length
      cur_req = "R6";
      pulse1_len = 16'd50;
      both(1'b0); wait_n(S_SHORT + 3); both(1'b1);
      wait_n(49);
      chk("R6 short len last", rst1_o, 1'b1);
      wait_n(1);
      chk("R6 short len end", rst1_o, 1'b0);
      chk("R6 rst2_n still on", rst2_n_o, 1'b0);
      wait_n(300);

      // R11: slower timebase
      cur_req = "R11";
      tick_div = 4;
      both(1'b0); wait_n(S_SHORT * 4 - 200); both(1'b1);
      wait_n(20);
      chk("R11 slow tick no early reset", rst1_o, 1'b0);
      both(1'b0); wait_n(S_SHORT * 4 + 20); both(1'b1);
      wait_n(P2 * 4 - 60);
      chk("R11 slow pulse still on", rst2_n_o, 1'b0);
      wait_n(120);
      chk("R11 slow pulse ended", rst2_n_o, 1'b1);
      wait_n(1500);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule